// File: doc/BRIEF.md
# LSB-first binary-GCD field divider

This block divides one element of GF(2^M) by another in polynomial basis. Given a dividend y, a divisor x and a reduction polynomial p, it returns q with q·x ≡ y (mod p). It does this by running an extended binary GCD that only ever looks at the lowest bit of its working polynomials, so it needs no degree detection and no multiplier. The polynomial arrives on an input with each request, which lets the same hardware serve any field of width M whose modulus has a nonzero constant term.

The datapath is a row of M identical one-bit slices. Each slice computes the next value of one bit of all four working registers from its own bits and its upper neighbour's bits. A small controller keeps a signed degree-difference estimate and counts cycles. A request is accepted with a one-cycle `start_i` when the block is idle. Exactly 5M−4 clock edges later `done_o` pulses and the quotient appears, whatever the operand values. A zero divisor or an even polynomial is reported on `err_o` together with `done_o`.

Top module: `gf2m_lsb_divider`

## Requirements
- R1: For a nonzero divisor x and a polynomial with constant term 1, the quotient output satisfies q·x ≡ y modulo p when done is high; this gives q = y for x = 1, q = 1 for x = y, and q = 0 for y = 0.
- R2: The polynomial is taken from poly_i at the accepted start as its low M coefficients; the coefficient of t^M is implied as 1. Back-to-back requests may use different polynomials.
- R3: done_o is high for exactly one cycle, and it is high after the 5M−4th rising edge that follows the edge which accepted start_i, whatever the operand values.
- R4: start_i is ignored while a request is in progress: no extra done pulse follows, and the running result is not disturbed.
- R5: If the divisor is zero or poly_i bit 0 is 0, err_o is high in the done cycle and the quotient output is zero; err_o is never high without done_o.
- R6: The quotient output changes only in a cycle where done_o is high and holds its value until the next done.
- R7: After reset, done_o and err_o are low and the quotient output is zero.
- R8: Operand and polynomial inputs are captured at the accepted start; changing them during the run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| dividend_i | input | M | Dividend y, bit i is the coefficient of t^i |
| divisor_i | input | M | Divisor x, bit i is the coefficient of t^i |
| poly_i | input | M | Low M coefficients of the modulus p |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero divisor or even modulus, valid with done_o |
| quot_o | output | M | Quotient q, held between completions |

## Verification
The checker follows each accepted request with its own cycle counter. On every cycle it checks that done appears at exactly 5M−4 edges and at no other time, that done lasts one cycle, that err only comes with done and forces a zero quotient, and that the quotient changes only on done. Whether the quotient is arithmetically right cannot be seen cycle by cycle. The bench shows it by multiplying the result back under two different moduli over random and directed operands. Only the bench's scenarios show that start pulses and operand changes during a run leave the result untouched.

// File: rtl/gf2m_div_pkg.sv
package gf2m_div_pkg;

   typedef enum logic {ST_IDLE, ST_RUN} div_state_e;

   function automatic int unsigned div_latency(input int unsigned m);
      return 5 * m - 4;
   endfunction

   function automatic int unsigned div_steps(input int unsigned m);
      return 2 * m;
   endfunction

endpackage

// File: rtl/gf2m_div_slice.sv
module gf2m_div_slice (
   input  logic odd,
   input  logic swap,
   input  logic red,
   input  logic a_hi,
   input  logic b_hi,
   input  logic u_hi,
   input  logic v_hi,
   input  logic p_hi,
   input  logic a_cur,
   input  logic b_cur,
   input  logic u_cur,
   input  logic v_cur,
   output logic a_nx,
   output logic b_nx,
   output logic u_nx,
   output logic v_nx
);
   // A <- (A + odd*B)/t ; U <- (U + odd*V + red*P)/t ; swap moves old A,U into B,V
   always_comb begin
      a_nx = a_hi ^ (odd & b_hi);
      u_nx = u_hi ^ (odd & v_hi) ^ (red & p_hi);
      b_nx = swap ? a_cur : b_cur;
      v_nx = swap ? u_cur : v_cur;
   end
endmodule

// File: rtl/gf2m_div_ctrl.sv
module gf2m_div_ctrl
   import gf2m_div_pkg::*;
#(
   parameter int unsigned M = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic a_lsb,
   output logic load_o,
   output logic step_o,
   output logic swap_o,
   output logic fire_o
);
   localparam int unsigned LAT   = div_latency(M);
   localparam int unsigned STEPS = div_steps(M);
   localparam int unsigned CW    = $clog2(LAT + 1);
   localparam int unsigned DW    = $clog2(2 * M + 2) + 1;
   localparam logic [CW-1:0] CNT_STEPS = CW'(STEPS);
   localparam logic [CW-1:0] CNT_LAST  = CW'(LAT);

   div_state_e              state_q;
   logic [CW-1:0]           cnt_q;
   logic signed [DW-1:0]    delta_q;
   logic signed [DW-1:0]    delta_nx;

   always_comb begin
      load_o   = (state_q == ST_IDLE) && start_i;
      step_o   = (state_q == ST_RUN) && (cnt_q <= CNT_STEPS);
      swap_o   = step_o && a_lsb && delta_q[DW-1];
      fire_o   = (state_q == ST_RUN) && (cnt_q == CNT_LAST);
      delta_nx = swap_o ? (-delta_q - DW'(1)) : (delta_q - DW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         delta_q <= '0;
      end else if (load_o) begin
         state_q <= ST_RUN;
         cnt_q   <= CW'(1);
         delta_q <= -DW'(1);
      end else if (state_q == ST_RUN) begin
         if (fire_o) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
         if (step_o) delta_q <= delta_nx;
      end
   end
endmodule

// File: rtl/gf2m_lsb_divider.sv
module gf2m_lsb_divider
   import gf2m_div_pkg::*;
#(
   parameter int unsigned M = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [M-1:0] dividend_i,
   input  logic [M-1:0] divisor_i,
   input  logic [M-1:0] poly_i,
   output logic         done_o,
   output logic         err_o,
   output logic [M-1:0] quot_o
);
   if (M < 2) begin : g_bad_width
      $error("gf2m_lsb_divider: M must be at least 2");
   end

   logic [M-1:0] a_q, u_q, v_q;
   logic [M:0]   b_q;
   logic [M-1:1] p_q;
   logic         bad_q;
   logic [M-1:0] a_nx, u_nx, v_nx, b_lo_nx;
   logic         load, step, swap, fire, odd, red;

   assign odd = a_q[0];
   assign red = u_q[0] ^ (odd & v_q[0]);

   gf2m_div_ctrl #(.M(M)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .a_lsb  (odd),
      .load_o (load),
      .step_o (step),
      .swap_o (swap),
      .fire_o (fire)
   );

   for (genvar i = 0; i < M; i++) begin : g_slice
      logic a_hi, b_hi, u_hi, v_hi, p_hi;
      if (i == M - 1) begin : g_top
         assign a_hi = 1'b0;
         assign b_hi = b_q[M];
         assign u_hi = 1'b0;
         assign v_hi = 1'b0;
         assign p_hi = 1'b1;
      end else begin : g_mid
         assign a_hi = a_q[i+1];
         assign b_hi = b_q[i+1];
         assign u_hi = u_q[i+1];
         assign v_hi = v_q[i+1];
         assign p_hi = p_q[i+1];
      end
      gf2m_div_slice u_pe (
         .odd  (odd),
         .swap (swap),
         .red  (red),
         .a_hi (a_hi),
         .b_hi (b_hi),
         .u_hi (u_hi),
         .v_hi (v_hi),
         .p_hi (p_hi),
         .a_cur(a_q[i]),
         .b_cur(b_q[i]),
         .u_cur(u_q[i]),
         .v_cur(v_q[i]),
         .a_nx (a_nx[i]),
         .b_nx (b_lo_nx[i]),
         .u_nx (u_nx[i]),
         .v_nx (v_nx[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         u_q   <= '0;
         v_q   <= '0;
         p_q   <= '0;
         bad_q <= 1'b0;
      end else if (load) begin
         a_q   <= divisor_i;
         b_q   <= {1'b1, poly_i};
         u_q   <= dividend_i;
         v_q   <= '0;
         p_q   <= poly_i[M-1:1];
         bad_q <= (divisor_i == '0) || !poly_i[0];
      end else if (step) begin
         a_q <= a_nx;
         b_q <= {b_q[M] & ~swap, b_lo_nx};
         u_q <= u_nx;
         v_q <= v_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         quot_o <= '0;
      end else begin
         done_o <= fire;
         err_o  <= fire && bad_q;
         if (fire) quot_o <= bad_q ? '0 : v_q;
      end
   end
endmodule

// File: rtl/gf2m_div_checker.sv
module gf2m_div_checker
   import gf2m_div_pkg::*;
#(
   parameter int unsigned M = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         done_o,
   input logic         err_o,
   input logic [M-1:0] quot_o
);
   localparam int unsigned LAT = div_latency(M);
   localparam int unsigned CW  = $clog2(LAT + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(LAT);

   logic          busy_c;
   logic [CW-1:0] cnt_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         cnt_c  <= '0;
      end else if (!busy_c && start_i) begin
         busy_c <= 1'b1;
         cnt_c  <= CW'(1);
      end else if (busy_c) begin
         if (cnt_c == CNT_LAST) begin
            busy_c <= 1'b0;
            cnt_c  <= '0;
         end else begin
            cnt_c <= cnt_c + CW'(1);
         end
      end
   end

   logic due;
   assign due = busy_c && (cnt_c == CNT_LAST);

   a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      due |=> done_o);
   a_r3_done_only_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      !due |=> !done_o);
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r5_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);
   a_r5_err_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (quot_o == '0));
   a_r6_quot_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quot_o) |-> done_o);
endmodule

bind gf2m_lsb_divider gf2m_div_checker #(.M(M)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .done_o (done_o),
   .err_o  (err_o),
   .quot_o (quot_o)
);

// File: tb/gf2m_lsb_divider_bench.sv
`timescale 1ns/1ps
module gf2m_lsb_divider_bench;
   localparam int unsigned M   = 8;
   localparam int unsigned LAT = 5 * M - 4;
   localparam logic [M-1:0] POLY_A = 8'h1B;
   localparam logic [M-1:0] POLY_B = 8'h1D;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [M-1:0] dividend_i = '0, divisor_i = '0, poly_i = '0;
   logic         done_o, err_o;
   logic [M-1:0] quot_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   gf2m_lsb_divider #(.M(M)) u_gf2m_lsb_divider (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i), .poly_i(poly_i),
      .done_o(done_o), .err_o(err_o), .quot_o(quot_o)
   );

   function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                                           input logic [M-1:0] p);
      logic [M-1:0] r = '0;
      for (int i = M - 1; i >= 0; i--) begin
         r = r[M-1] ? ((r << 1) ^ p) : (r << 1);
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   function automatic logic [M-1:0] gf_div_ref(input logic [M-1:0] y, input logic [M-1:0] x,
                                               input logic [M-1:0] p);
      for (int q = 0; q < (1 << M); q++)
         if (gf_mul(M'(q), x, p) == y) return M'(q);
      return '0;
   endfunction

   task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One request; optionally disturb inputs and pulse start mid-run (R4, R8).
   task automatic run_div(input logic [M-1:0] y, input logic [M-1:0] x,
                          input logic [M-1:0] p, input bit disturb, input string req);
      logic [M-1:0] exp_q;
      logic         exp_e;
      int           early = 0;
      logic         done_at = 1'b0;
      exp_e = (x == '0) || !p[0];
      exp_q = exp_e ? '0 : gf_div_ref(y, x, p);
      @(negedge clk);
      dividend_i = y; divisor_i = x; poly_i = p; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 1; k <= LAT; k++) begin
         if (disturb && k == 7) begin
            dividend_i = ~y; divisor_i = x ^ 8'h5A; poly_i = POLY_B ^ 8'h40;
            start_i = 1'b1;
         end else if (disturb && k == 8) begin
            start_i = 1'b0;
         end
         @(posedge clk); #1;
         if (k < LAT && done_o) early++;
         if (k == LAT) done_at = done_o;
         if (k < LAT) @(negedge clk);
      end
      check({req, " R3 latency/early done"}, M'(early), '0);
      check({req, " R3 done at 5M-4"}, M'(done_at), M'(1));
      check({req, " R1 quotient"}, quot_o, exp_q);
      check({req, " R5 err"}, M'(err_o), M'(exp_e));
      @(posedge clk); #1;
      check({req, " R3 done one cycle"}, M'(done_o), '0);
      if (disturb) begin
         for (int k = 0; k < LAT + 4; k++) begin
            @(posedge clk); #1;
            if (done_o) early++;
         end
         check({req, " R4 no second done"}, M'(early), '0);
         check({req, " R6 quotient held"}, quot_o, exp_q);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      check("R7 reset done", M'(done_o), '0);
      check("R7 reset err", M'(err_o), '0);
      check("R7 reset quot", quot_o, '0);
      @(negedge clk); rst_n = 1'b1;

      run_div(8'h57, 8'h01, POLY_A, 1'b0, "R1 x=1");
      run_div(8'hC3, 8'hC3, POLY_A, 1'b0, "R1 x=y");
      run_div(8'h00, 8'h9E, POLY_A, 1'b0, "R1 y=0");
      run_div(8'hFF, 8'hFF, POLY_B, 1'b0, "R2 poly B x=y");
      run_div(8'h80, 8'h80, POLY_B, 1'b0, "R2 high bits");
      run_div(8'h01, 8'h02, POLY_A, 1'b0, "R1 inverse of t");
      run_div(8'h34, 8'h00, POLY_A, 1'b0, "R5 zero divisor");
      run_div(8'h34, 8'h12, 8'h1A, 1'b0, "R5 even poly");
      run_div(8'hA5, 8'h3C, POLY_A, 1'b1, "R4 R8 busy start");
      run_div(8'h6E, 8'hD1, POLY_B, 1'b1, "R8 R2 busy change");

      for (int n = 0; n < 200; n++) begin
         logic [M-1:0] x, y;
         x = M'($urandom);
         if (x == '0) x = 8'h01;
         y = M'($urandom);
         run_div(y, x, n[0] ? POLY_B : POLY_A, 1'b0, "R1 R2 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule